// File: doc/BRIEF.md
# Nearest-Level Gate Pattern Generator for a Cascaded Multilevel Inverter

This block turns a stream of signed reference samples into the gate commands of a single-phase cascaded multilevel stage. The stage has three series cells and an output H-bridge. The first cell is a two-switch cell that always contributes 1 or 2 units. The other two are switched-diode cells that each contribute 0, a low value or a high value. The low and high values are 2 and 3 units. In asymmetrical mode the second switched-diode cell runs from sources of double value, so its low and high values become 4 and 6 units.

On each sample strobe the block scales the reference by a modulation gain. It rounds the result to the nearest level the stage can produce and clamps it to the range of the selected mode. The magnitude is split across the three cells with a fixed table, and the sign is given to the bridge. All gate outputs are registered and move only on a strobe.

Interlocks hold by construction, and a bound checker watches them. A switched-diode cell never turns on its upper switches while its main switch is off. The two-switch cell never has both switches on. For a zero level the bridge shorts the load through one of its two zero pairs, chosen in alternation. The cell switches keep their previous state during a zero level.

Top module: `nlc_gate_top`

## Requirements
- R1: On a strobe the level is round-half-up of ref·gain·M / 2^22, where ref is a two's complement fraction with 15 fractional bits, gain is unsigned with 7 fractional bits, and M is 8 in symmetrical mode (asym_sel=0) or 11 in asymmetrical mode. At a gain of 13 (about 0.1) in symmetrical mode only the levels -1, 0 and +1 occur.
- R2: The rounded level is clamped to ±8 in symmetrical mode and to ±11 in asymmetrical mode. `lvl_out` reports the clamped level.
- R3: Symmetrical split of magnitude m as (two-switch, cell 1, cell 2) units: 1=(1,0,0), 2=(2,0,0), 3=(1,2,0), 4=(2,2,0), 5=(2,3,0), 6=(1,2,3), 7=(2,2,3), 8=(2,3,3). Two-switch gates {Sb,Sa}: 01 gives 1 unit and 10 gives 2 units. Switched-diode gates {S3,S2,S1}: 000 is off, 101 is low (2 units) and 011 is high (3 units).
- R4: Asymmetrical split: magnitudes 1 to 5 split as in R3. The rest split as 6=(2,0,4), 7=(1,2,4), 8=(2,2,4), 9=(2,3,4), 10=(2,2,6), 11=(2,3,6). In this mode cell 2 low is 4 units and cell 2 high is 6 units.
- R5: In either switched-diode cell, S2 or S3 is never on while S1 is off.
- R6: Exactly one of Sa and Sb is on at all times.
- R7: Bridge gates {T4,T3,T2,T1} are 1001 for a positive level and 0110 for a negative level. For a zero level they are 0011 or 1100.
- R8: A strobe that moves from a nonzero level to zero switches to the other zero pair. Later zero strobes keep the same pair.
- R9: A zero-level strobe leaves every cell gate unchanged.
- R10: Outputs change only at the clock edge where `smp_stb` is high, taking effect after that edge. Without a strobe, all outputs hold whatever the inputs do.
- R11: After reset, tw_gate=01, both switched-diode gates are 000, hb_gate=0011 and lvl_out=0. The first zero level after reset keeps pair 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; inputs are taken at this edge |
| ref_smp | input | 16 | Signed reference sample, 15 fractional bits |
| mod_gain | input | 8 | Unsigned modulation gain, 7 fractional bits |
| asym_sel | input | 1 | 1 selects asymmetrical (23-level) mode |
| lvl_out | output | 5 | Signed level now applied |
| tw_gate | output | 2 | Two-switch cell gates {Sb,Sa} |
| sd1_gate | output | 3 | Switched-diode cell 1 gates {S3,S2,S1} |
| sd2_gate | output | 3 | Switched-diode cell 2 gates {S3,S2,S1} |
| hb_gate | output | 4 | H-bridge gates {T4,T3,T2,T1} |

## Verification
Each result has one register stage. The level, cell gates and bridge gates for a strobe all appear together just after the edge that sampled the strobe, with no further delay. The bench drives inputs on the falling edge and updates its model right after the next rising edge. It compares every output 1 ns after that rising edge, so every comparison falls in the first cycle where the new pattern is due. Cycles without a strobe are compared against the held model state in the same way, which covers R10 without a separate schedule.

// File: rtl/nlc_pkg.sv
`timescale 1ns/1ps
package nlc_pkg;
  localparam int LVL_W = 5;
  localparam int MAG_W = LVL_W - 1;
  localparam int N_SD  = 2;

  typedef enum logic { TW_ONE = 1'b0, TW_TWO = 1'b1 } tw_sel_e;
  typedef enum logic [1:0] { SD_OFF = 2'd0, SD_LOW = 2'd1, SD_HIGH = 2'd2 } sd_sel_e;

  typedef struct packed {
    tw_sel_e tw;
    sd_sel_e sd1;
    sd_sel_e sd2;
  } plan_t;

  localparam logic [3:0] HB_POS = 4'b1001;
  localparam logic [3:0] HB_NEG = 4'b0110;
  localparam logic [3:0] HB_ZA  = 4'b0011;
  localparam logic [3:0] HB_ZB  = 4'b1100;

  function automatic plan_t mk(input tw_sel_e t, input sd_sel_e a, input sd_sel_e b);
    plan_t p;
    p.tw = t; p.sd1 = a; p.sd2 = b;
    return p;
  endfunction

  // magnitude -> per-cell selection; cell 2 is the doubled cell in asym mode
  function automatic plan_t split_level(input logic [MAG_W-1:0] mag, input logic asym);
    plan_t p;
    p = mk(TW_ONE, SD_OFF, SD_OFF);
    if (!asym || mag <= 4'd5) begin
      case (mag)
        4'd1: p = mk(TW_ONE, SD_OFF,  SD_OFF);
        4'd2: p = mk(TW_TWO, SD_OFF,  SD_OFF);
        4'd3: p = mk(TW_ONE, SD_LOW,  SD_OFF);
        4'd4: p = mk(TW_TWO, SD_LOW,  SD_OFF);
        4'd5: p = mk(TW_TWO, SD_HIGH, SD_OFF);
        4'd6: p = mk(TW_ONE, SD_LOW,  SD_HIGH);
        4'd7: p = mk(TW_TWO, SD_LOW,  SD_HIGH);
        4'd8: p = mk(TW_TWO, SD_HIGH, SD_HIGH);
        default: p = mk(TW_ONE, SD_OFF, SD_OFF);
      endcase
    end else begin
      case (mag)
        4'd6:  p = mk(TW_TWO, SD_OFF,  SD_LOW);
        4'd7:  p = mk(TW_ONE, SD_LOW,  SD_LOW);
        4'd8:  p = mk(TW_TWO, SD_LOW,  SD_LOW);
        4'd9:  p = mk(TW_TWO, SD_HIGH, SD_LOW);
        4'd10: p = mk(TW_TWO, SD_LOW,  SD_HIGH);
        4'd11: p = mk(TW_TWO, SD_HIGH, SD_HIGH);
        default: p = mk(TW_ONE, SD_OFF, SD_OFF);
      endcase
    end
    return p;
  endfunction

  // {Sb,Sa}
  function automatic logic [1:0] tw_gates(input tw_sel_e s);
    return (s == TW_TWO) ? 2'b10 : 2'b01;
  endfunction

  // {S3,S2,S1}
  function automatic logic [2:0] sd_gates(input sd_sel_e s);
    case (s)
      SD_LOW:  return 3'b101;
      SD_HIGH: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/nlc_quantizer.sv
`timescale 1ns/1ps
module nlc_quantizer
  import nlc_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int MI_W     = 8,
  parameter int SYM_MAX  = 8,
  parameter int ASYM_MAX = 11
) (
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic        [MI_W-1:0]  mod_gain,
  input  logic                    asym_sel,
  output logic signed [LVL_W-1:0] level,
  output logic        [MAG_W-1:0] mag,
  output logic                    neg,
  output logic                    zero
);
  localparam int FRAC   = REF_W + MI_W - 2;
  localparam int PROD_W = REF_W + MI_W + 6;
  localparam logic signed [PROD_W-1:0] HALF =
    {{(PROD_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [PROD_W-1:0] ref_x, gain_x, lim, prod, q, q_sat;

  always_comb begin
    ref_x  = {{(PROD_W-REF_W){ref_smp[REF_W-1]}}, ref_smp};
    gain_x = {{(PROD_W-MI_W){1'b0}}, mod_gain};
    lim    = asym_sel ? PROD_W'(ASYM_MAX) : PROD_W'(SYM_MAX);
    prod   = ref_x * gain_x * lim;
    q      = (prod + HALF) >>> FRAC;
    if (q > lim)       q_sat = lim;
    else if (q < -lim) q_sat = -lim;
    else               q_sat = q;
  end

  assign level = LVL_W'(q_sat);
  assign neg   = level[LVL_W-1];
  assign zero  = (level == '0);
  assign mag   = MAG_W'(neg ? -level : level);
endmodule

// File: rtl/nlc_cell_map.sv
`timescale 1ns/1ps
module nlc_cell_map
  import nlc_pkg::*;
(
  input  logic [MAG_W-1:0]         mag,
  input  logic                     asym_sel,
  output logic [1:0]               tw_next,
  output logic [N_SD-1:0][2:0]     sd_next
);
  plan_t   plan;
  sd_sel_e sd_sel [N_SD];

  always_comb begin
    plan      = split_level(mag, asym_sel);
    sd_sel[0] = plan.sd1;
    sd_sel[1] = plan.sd2;
  end

  assign tw_next = tw_gates(plan.tw);

  for (genvar i = 0; i < N_SD; i++) begin : g_sd
    assign sd_next[i] = sd_gates(sd_sel[i]);
  end
endmodule

// File: rtl/nlc_gate_reg.sv
`timescale 1ns/1ps
module nlc_gate_reg
  import nlc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic signed [LVL_W-1:0]  level,
  input  logic                     neg,
  input  logic                     zero,
  input  logic [1:0]               tw_next,
  input  logic [N_SD-1:0][2:0]     sd_next,
  output logic signed [LVL_W-1:0]  lvl_q,
  output logic [1:0]               tw_q,
  output logic [N_SD-1:0][2:0]     sd_q,
  output logic [3:0]               hb_q,
  output logic                     zero_entry
);
  logic zsel_q;
  logic zsel_nx;

  assign zero_entry = smp_stb && zero && (lvl_q != '0);
  assign zsel_nx    = zero_entry ? ~zsel_q : zsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      tw_q   <= 2'b01;
      sd_q   <= '0;
      hb_q   <= HB_ZA;
      zsel_q <= 1'b0;
    end else if (smp_stb) begin
      lvl_q  <= level;
      zsel_q <= zsel_nx;
      if (zero) begin
        hb_q <= zsel_nx ? HB_ZB : HB_ZA;
      end else begin
        tw_q <= tw_next;
        sd_q <= sd_next;
        hb_q <= neg ? HB_NEG : HB_POS;
      end
    end
  end
endmodule

// File: rtl/nlc_gate_top.sv
`timescale 1ns/1ps
module nlc_gate_top
  import nlc_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int MI_W     = 8,
  parameter int SYM_MAX  = 8,
  parameter int ASYM_MAX = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic signed [REF_W-1:0] ref_smp,
  input  logic        [MI_W-1:0]  mod_gain,
  input  logic                    asym_sel,
  output logic signed [LVL_W-1:0] lvl_out,
  output logic        [1:0]       tw_gate,
  output logic        [2:0]       sd1_gate,
  output logic        [2:0]       sd2_gate,
  output logic        [3:0]       hb_gate
);
  logic signed [LVL_W-1:0] level;
  logic [MAG_W-1:0]        mag;
  logic                    neg, zero_req, zero_entry;
  logic [1:0]              tw_next;
  logic [N_SD-1:0][2:0]    sd_next, sd_q;

  nlc_quantizer #(
    .REF_W(REF_W), .MI_W(MI_W), .SYM_MAX(SYM_MAX), .ASYM_MAX(ASYM_MAX)
  ) u_quant (
    .ref_smp(ref_smp), .mod_gain(mod_gain), .asym_sel(asym_sel),
    .level(level), .mag(mag), .neg(neg), .zero(zero_req)
  );

  nlc_cell_map u_map (
    .mag(mag), .asym_sel(asym_sel), .tw_next(tw_next), .sd_next(sd_next)
  );

  nlc_gate_reg u_reg (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .level(level), .neg(neg), .zero(zero_req),
    .tw_next(tw_next), .sd_next(sd_next),
    .lvl_q(lvl_out), .tw_q(tw_gate), .sd_q(sd_q), .hb_q(hb_gate),
    .zero_entry(zero_entry)
  );

  assign sd1_gate = sd_q[0];
  assign sd2_gate = sd_q[1];
endmodule

// File: rtl/nlc_gate_checker.sv
`timescale 1ns/1ps
module nlc_gate_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic              asym_sel,
  input logic              zero_req,
  input logic              zero_entry,
  input logic signed [4:0] lvl_out,
  input logic [1:0]        tw_gate,
  input logic [2:0]        sd1_gate,
  input logic [2:0]        sd2_gate,
  input logic [3:0]        hb_gate
);
  a_r5_sd1_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    (sd1_gate[1] || sd1_gate[2]) |-> sd1_gate[0]);

  a_r5_sd2_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    (sd2_gate[1] || sd2_gate[2]) |-> sd2_gate[0]);

  a_r6_tw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tw_gate) == 1);

  a_r7_bridge_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_gate == 4'b1001) || (hb_gate == 4'b0110) ||
    (hb_gate == 4'b0011) || (hb_gate == 4'b1100));

  a_r7_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_out > 0) |-> (hb_gate == 4'b1001));

  a_r8_zero_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && zero_req && !zero_entry) |=> $stable(hb_gate));

  a_r9_zero_keeps_cells: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && zero_req) |=> ($stable(tw_gate) && $stable(sd1_gate) && $stable(sd2_gate)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(tw_gate) && $stable(sd1_gate) && $stable(sd2_gate) &&
                  $stable(hb_gate) && $stable(lvl_out)));

  a_r2_sym_range: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !asym_sel) |=> (lvl_out <= 5'sd8 && lvl_out >= -5'sd8));

  a_r2_asym_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_out <= 5'sd11 && lvl_out >= -5'sd11));
endmodule

bind nlc_gate_top nlc_gate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .asym_sel(asym_sel),
  .zero_req(zero_req), .zero_entry(zero_entry), .lvl_out(lvl_out),
  .tw_gate(tw_gate), .sd1_gate(sd1_gate), .sd2_gate(sd2_gate), .hb_gate(hb_gate)
);

// File: tb/nlc_gate_top_bench.sv
`timescale 1ns/1ps
module nlc_gate_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [15:0] ref_smp = '0;
  logic [7:0] mod_gain = '0;
  logic asym_sel = 1'b0;
  logic signed [4:0] lvl_out;
  logic [1:0] tw_gate;
  logic [2:0] sd1_gate, sd2_gate;
  logic [3:0] hb_gate;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_lvl = 0;
  int m_tw = 1, m_c1 = 0, m_c2 = 0;
  bit m_cmode = 0;
  bit m_zb = 0;
  int lfsr = 32'h1ACE5;

  always #2.5 clk = ~clk;

  nlc_gate_top u_nlc_gate_top (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ref_smp(ref_smp),
    .mod_gain(mod_gain), .asym_sel(asym_sel), .lvl_out(lvl_out),
    .tw_gate(tw_gate), .sd1_gate(sd1_gate), .sd2_gate(sd2_gate), .hb_gate(hb_gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int want_level(input int r, input int g, input bit a);
    longint p;
    int l, lim;
    lim = a ? 11 : 8;
    p = longint'(r) * longint'(g) * longint'(lim);
    l = int'($floor(real'(p) / 4194304.0 + 0.5));
    if (l > lim) l = lim;
    if (l < -lim) l = -lim;
    return l;
  endfunction

  // units per cell for a magnitude (R3 symmetrical, R4 asymmetrical)
  task automatic want_split(input int m, input bit a, output int t, output int c1, output int c2);
    t = 0; c1 = 0; c2 = 0;
    if (!a || m <= 5) begin
      case (m)
        1: begin t=1; c1=0; c2=0; end
        2: begin t=2; c1=0; c2=0; end
        3: begin t=1; c1=2; c2=0; end
        4: begin t=2; c1=2; c2=0; end
        5: begin t=2; c1=3; c2=0; end
        6: begin t=1; c1=2; c2=3; end
        7: begin t=2; c1=2; c2=3; end
        8: begin t=2; c1=3; c2=3; end
        default: ;
      endcase
    end else begin
      case (m)
        6:  begin t=2; c1=0; c2=4; end
        7:  begin t=1; c1=2; c2=4; end
        8:  begin t=2; c1=2; c2=4; end
        9:  begin t=2; c1=3; c2=4; end
        10: begin t=2; c1=2; c2=6; end
        11: begin t=2; c1=3; c2=6; end
        default: ;
      endcase
    end
  endtask

  function automatic int tw_units(input logic [1:0] g);
    if (g == 2'b01) return 1;
    if (g == 2'b10) return 2;
    return -1;
  endfunction

  function automatic int sd_units(input logic [2:0] g, input int lo);
    if (g == 3'b000) return 0;
    if (g == 3'b101) return lo;
    if (g == 3'b011) return (lo == 4) ? 6 : 3;
    return -1;
  endfunction

  task automatic compare(input string tag_lvl, input string tag_cell, input string tag_hb);
    int e_hb;
    e_hb = (m_lvl > 0) ? 4'b1001 : (m_lvl < 0) ? 4'b0110 : (m_zb ? 4'b1100 : 4'b0011);
    chk(int'(lvl_out) == m_lvl, tag_lvl, int'(lvl_out), m_lvl);
    chk(tw_units(tw_gate) == m_tw, {tag_cell, " two-switch"}, tw_units(tw_gate), m_tw);
    chk(sd_units(sd1_gate, 2) == m_c1, {tag_cell, " cell1"}, sd_units(sd1_gate, 2), m_c1);
    chk(sd_units(sd2_gate, m_cmode ? 4 : 2) == m_c2, {tag_cell, " cell2"},
        sd_units(sd2_gate, m_cmode ? 4 : 2), m_c2);
    chk(int'(hb_gate) == e_hb, tag_hb, int'(hb_gate), e_hb);
    chk(!((sd1_gate[1] | sd1_gate[2]) & ~sd1_gate[0]) &&
        !((sd2_gate[1] | sd2_gate[2]) & ~sd2_gate[0]), "R5 interlock",
        int'({sd2_gate, sd1_gate}), 0);
    chk(tw_gate == 2'b01 || tw_gate == 2'b10, "R6 exclusive", int'(tw_gate), 1);
  endtask

  task automatic step(input bit en, input int r, input int g, input bit a);
    int l, t, c1, c2;
    string tl, tc, th;
    @(negedge clk);
    smp_stb = en; ref_smp = 16'(r); mod_gain = 8'(g); asym_sel = a;
    @(posedge clk);
    #1;
    tl = "R10 hold level"; tc = "R10 hold cells"; th = "R10 hold bridge";
    if (en) begin
      l = want_level(r, g, a);
      tl = ((l == 8 || l == -8) && !a) || l == 11 || l == -11 ? "R2 clamp" : "R1 level";
      th = "R7 bridge";
      if (l == 0) begin
        if (m_lvl != 0) m_zb = ~m_zb;
        tc = "R9 zero keeps cells"; th = "R8 zero pair";
      end else begin
        want_split(l < 0 ? -l : l, a, t, c1, c2);
        m_tw = t; m_c1 = c1; m_c2 = c2; m_cmode = a;
        tc = a ? "R4 asym split" : "R3 sym split";
        chk(t + c1 + c2 == (l < 0 ? -l : l), tc, t + c1 + c2, l);
      end
      m_lvl = l;
    end
    compare(tl, tc, th);
  endtask

  function automatic int next_rand(input int v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo, hi, lv;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(tw_gate == 2'b01, "R11 reset tw", int'(tw_gate), 1);
    chk(sd1_gate == 3'b000 && sd2_gate == 3'b000, "R11 reset cells",
        int'({sd2_gate, sd1_gate}), 0);
    chk(hb_gate == 4'b0011, "R11 reset bridge", int'(hb_gate), 3);
    chk(lvl_out == 0, "R11 reset level", int'(lvl_out), 0);
    @(negedge clk); rst_n = 1'b1;
    // R11: first zero after reset keeps pair A
    step(1, 0, 128, 0);
    chk(hb_gate == 4'b0011, "R11 first zero pair", int'(hb_gate), 3);

    // R1/R3 symmetrical sweep, then R4 asymmetrical
    for (int k = -18; k <= 18; k++) step(1, k * 1800, 128, 0);
    for (int k = -18; k <= 18; k++) step(1, k * 1800, 128, 1);
    for (int k = -18; k <= 18; k++) step(1, k * 1800, 200, 1);

    // R1 low gain: only three levels
    lo = 0; hi = 0;
    for (int k = -16; k <= 16; k++) begin
      step(1, k * 2047, 13, 0);
      lv = int'(lvl_out);
      if (lv < lo) lo = lv;
      if (lv > hi) hi = lv;
    end
    chk(lo == -1 && hi == 1, "R1 low gain span", hi - lo, 2);

    // R2 clamps
    step(1, 32767, 255, 0);
    chk(lvl_out == 8, "R2 sym clamp +", int'(lvl_out), 8);
    step(1, -32768, 255, 0);
    chk(lvl_out == -8, "R2 sym clamp -", int'(lvl_out), -8);
    step(1, 32767, 255, 1);
    chk(lvl_out == 11, "R2 asym clamp +", int'(lvl_out), 11);
    step(1, -32768, 255, 1);
    chk(lvl_out == -11, "R2 asym clamp -", int'(lvl_out), -11);

    // R10 no strobe, wild inputs
    for (int k = 0; k < 6; k++) step(0, (k * 9001) - 20000, 100 + k * 20, k[0]);

    // R8 zero alternation and R9 cell hold
    step(1, 20000, 128, 0);
    step(1, 0, 128, 0);
    chk(hb_gate == 4'b1100, "R8 second pair", int'(hb_gate), 12);
    step(1, 100, 128, 0);
    chk(hb_gate == 4'b1100, "R8 pair kept", int'(hb_gate), 12);
    step(1, -12000, 128, 1);
    step(1, 0, 128, 0);
    chk(hb_gate == 4'b0011, "R8 back to first pair", int'(hb_gate), 3);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      lfsr = next_rand(lfsr);
      step(lfsr[3:0] != 0, int'($signed(lfsr[31:16])), int'(lfsr[11:4]), lfsr[13]);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule